// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the power-down state of a small processor core. A one-cycle sleep strobe from the instruction decoder turns the core's phase clocks off and restarts the watchdog. While asleep, the block watches two kinds of wake event. Reset-type events are power-on, brown-out, external reset and watchdog time-out. Interrupt-type events are any source whose enable bit and pending flag are both set. The global interrupt mask does not block an interrupt wake.

When a wake event arrives, the block restarts the watchdog again. For crystal-type oscillator settings it first holds the core for a fixed start-up interval. It then raises the clock enable together with a one-cycle wake pulse. Alongside that pulse, a flag tells the core whether to branch to the interrupt vector after the next instruction or to keep executing in line. A reset-type event also issues a device reset request. The block keeps two status bits for the core's status register: a power-down bit and a time-out bit.

The block carries no data stream. Every pin is a plain level or strobe control or status signal, and there is no back-pressure anywhere.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `core_clk_en`=1, `status_pd`=1, `status_to`=1, and `wake_pulse`, `take_irq`, `dev_reset_req` and `wdt_clear` are 0.
- R2: Assume the core is running, `sleep_req` is high and no reset event is present. After the next edge `core_clk_en`=0, `status_pd`=0 and `status_to`=1, and `wdt_clear` is high for exactly that one cycle.
- R3: While asleep with no wake event, `core_clk_en`, `wake_pulse` and `wdt_clear` stay 0.
- R4: An interrupt source wakes the core only when its `irq_en` bit and its `irq_flag` bit are both 1. It does so whatever the value of `glb_irq_mask`. A flag whose enable bit is 0 has no effect.
- R5: Together with the wake pulse of an interrupt wake, `take_irq` is 1 if `glb_irq_mask` was 0 at the wake edge and 0 if it was 1. `take_irq` is never high without `wake_pulse`.
- R6: `wdt_clear` pulses for one cycle on the edge at which any wake event is accepted, whatever its source.
- R7: `osc_mode` encodes 0=RC, 1=XT, 2=LF, 3=EC. In RC and EC, `core_clk_en` rises on the same edge that accepts the wake. In XT and LF, `core_clk_en` stays 0 for exactly `OST_CYCLES` (default 1024) further cycles after that edge.
- R8: If an enabled interrupt is already pending when sleep is entered, the block still enters sleep with `status_pd`=0 and `status_to`=1. It then accepts the wake on the first sleeping cycle.
- R9: `dev_reset_req` is high in the cycle after any cycle in which `por_evt`, `bor_evt`, `ext_rst_evt` or `wdt_timeout` is high. The status bits then change as follows. `wdt_timeout` clears `status_to`. `por_evt` sets both bits and takes priority over `wdt_timeout`. `bor_evt` and `ext_rst_evt` leave both bits as they were. A reset-type wake gives `take_irq`=0.
- R10: A `sleep_req` that arrives while the core is asleep or in the start-up hold is ignored. It produces no `wdt_clear`, no change in the status bits and no change in the timing of the wake.
- R11: `wake_pulse` is high for exactly the one cycle in which `core_clk_en` first returns to 1 after sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | Sleep strobe from the instruction decoder |
| osc_mode | input | 2 | Oscillator setting: 0 RC, 1 XT, 2 LF, 3 EC |
| glb_irq_mask | input | 1 | Global interrupt mask (1 = interrupts disabled) |
| irq_en | input | N_IRQ | Per-source interrupt enable bits |
| irq_flag | input | N_IRQ | Per-source interrupt pending flags |
| por_evt | input | 1 | Power-on reset event |
| bor_evt | input | 1 | Brown-out reset event |
| ext_rst_evt | input | 1 | External reset pin event |
| wdt_timeout | input | 1 | Watchdog time-out event |
| core_clk_en | output | 1 | Enables the core phase clocks |
| wake_pulse | output | 1 | One-cycle pulse as the clocks resume |
| take_irq | output | 1 | Branch to the interrupt vector after the next instruction |
| dev_reset_req | output | 1 | Full device reset request |
| wdt_clear | output | 1 | Clears the watchdog counter and postscaler |
| status_to | output | 1 | Time-out status bit |
| status_pd | output | 1 | Power-down status bit |

## Verification
The embedded properties assume three things about the inputs. First, `sleep_req` is a strobe that the core raises only while it is running. Second, the reset-event inputs are pulses and not long levels. Third, a pending flag is not dropped in the same cycle as it is sampled. The stimulus follows all three. It drives every input 1 ns after a rising edge and holds it for a whole cycle. It pulses each reset event for a single cycle, and it clears the interrupt flags only after the wake has been accepted. The bench also sends sleep strobes while the core is asleep or in the start-up hold. This covers the case where the assumption is broken on purpose to exercise R10.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_HOLD  = 2'd2
  } sw_state_e;

  typedef enum logic [1:0] {
    OSC_RC = 2'd0,
    OSC_XT = 2'd1,
    OSC_LF = 2'd2,
    OSC_EC = 2'd3
  } osc_mode_e;

  // Crystal-type settings need the start-up hold before clocks resume.
  function automatic logic needs_hold(input logic [1:0] mode);
    return (mode == OSC_XT) || (mode == OSC_LF);
  endfunction
endpackage

// File: rtl/sw_wake_detect.sv
module sw_wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic             por_evt,
  input  logic             bor_evt,
  input  logic             ext_rst_evt,
  input  logic             wdt_timeout,
  output logic             irq_pending,
  output logic             rst_event
);
  logic [N_IRQ-1:0] armed;

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_src
      assign armed[gi] = irq_en[gi] & irq_flag[gi];
    end
  endgenerate

  assign irq_pending = |armed;
  assign rst_event   = por_evt | bor_evt | ext_rst_evt | wdt_timeout;
endmodule

// File: rtl/sw_ost_timer.sv
module sw_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(OST_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R7: the hold counter never runs past the configured interval
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/sw_status_bits.sv
module sw_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt,
  input  logic wdt_timeout,
  input  logic sleep_enter,
  output logic status_to,
  output logic status_pd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_to <= 1'b1;
      status_pd <= 1'b1;
    end else if (por_evt) begin
      status_to <= 1'b1;
      status_pd <= 1'b1;
    end else if (wdt_timeout) begin
      status_to <= 1'b0;
    end else if (sleep_enter) begin
      status_to <= 1'b1;
      status_pd <= 1'b0;
    end
  end

  assert_por_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (status_to && status_pd));
  assert_wdt_clears_to_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !por_evt) |=> !status_to);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ      = 8,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [1:0]       osc_mode,
  input  logic             glb_irq_mask,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic             por_evt,
  input  logic             bor_evt,
  input  logic             ext_rst_evt,
  input  logic             wdt_timeout,
  output logic             core_clk_en,
  output logic             wake_pulse,
  output logic             take_irq,
  output logic             dev_reset_req,
  output logic             wdt_clear,
  output logic             status_to,
  output logic             status_pd
);
  import sw_pkg::*;

  sw_state_e state;
  logic irq_pending, rst_event;
  logic sleep_enter, wake_now, hold_next, ost_done;
  logic vector_q;

  sw_wake_detect #(.N_IRQ(N_IRQ)) u_detect (
    .irq_en      (irq_en),
    .irq_flag    (irq_flag),
    .por_evt     (por_evt),
    .bor_evt     (bor_evt),
    .ext_rst_evt (ext_rst_evt),
    .wdt_timeout (wdt_timeout),
    .irq_pending (irq_pending),
    .rst_event   (rst_event)
  );

  assign sleep_enter = (state == ST_RUN) && sleep_req && !rst_event;
  assign wake_now    = (state == ST_SLEEP) && (irq_pending || rst_event);
  assign hold_next   = needs_hold(osc_mode);

  sw_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_now && hold_next),
    .run   (state == ST_HOLD),
    .done  (ost_done)
  );

  sw_status_bits u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_evt     (por_evt),
    .wdt_timeout (wdt_timeout),
    .sleep_enter (sleep_enter),
    .status_to   (status_to),
    .status_pd   (status_pd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_RUN;
      vector_q      <= 1'b0;
      wake_pulse    <= 1'b0;
      take_irq      <= 1'b0;
      dev_reset_req <= 1'b0;
      wdt_clear     <= 1'b0;
    end else begin
      wake_pulse    <= 1'b0;
      take_irq      <= 1'b0;
      dev_reset_req <= rst_event;
      wdt_clear     <= sleep_enter || wake_now;
      unique case (state)
        ST_RUN: begin
          if (sleep_enter) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wake_now) begin
            if (hold_next) begin
              state    <= ST_HOLD;
              vector_q <= !rst_event && !glb_irq_mask;
            end else begin
              state      <= ST_RUN;
              wake_pulse <= 1'b1;
              take_irq   <= !rst_event && !glb_irq_mask;
            end
          end
        end
        ST_HOLD: begin
          if (rst_event) vector_q <= 1'b0;
          if (ost_done) begin
            state      <= ST_RUN;
            wake_pulse <= 1'b1;
            take_irq   <= vector_q && !rst_event;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign core_clk_en = (state == ST_RUN);

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> (!core_clk_en && !status_pd && status_to && wdt_clear));
  assert_ignored_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && sleep_req) |=> !wdt_clear);
  assert_vector_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> wake_pulse);
  assert_reset_no_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_req |-> !take_irq);
  assert_wake_on_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> wake_pulse);
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_wake_clears_wdt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_now |=> wdt_clear);
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  localparam int N_IRQ = 8;
  localparam int OST   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [1:0] osc_mode = 2'd0;
  logic glb_irq_mask = 1'b0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic [N_IRQ-1:0] irq_flag = '0;
  logic por_evt = 1'b0, bor_evt = 1'b0, ext_rst_evt = 1'b0, wdt_timeout = 1'b0;
  logic core_clk_en, wake_pulse, take_irq, dev_reset_req, wdt_clear, status_to, status_pd;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .osc_mode(osc_mode),
    .glb_irq_mask(glb_irq_mask), .irq_en(irq_en), .irq_flag(irq_flag),
    .por_evt(por_evt), .bor_evt(bor_evt), .ext_rst_evt(ext_rst_evt),
    .wdt_timeout(wdt_timeout), .core_clk_en(core_clk_en), .wake_pulse(wake_pulse),
    .take_irq(take_irq), .dev_reset_req(dev_reset_req), .wdt_clear(wdt_clear),
    .status_to(status_to), .status_pd(status_pd)
  );

  function automatic bit exp_hold(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  function automatic bit exp_take(input bit mask, input bit by_reset);
    return !mask && !by_reset;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check("WATCHDOG", "run did not finish", 0, 1);
      finish_run();
    end
  end

  task automatic enter_sleep();
    irq_flag = '0;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R2", "clk_en after sleep", core_clk_en, 0);
    check("R2", "pd after sleep", status_pd, 0);
    check("R2", "to after sleep", status_to, 1);
    check("R2", "wdt_clear on entry", wdt_clear, 1);
    step();
    check("R2", "wdt_clear one cycle", wdt_clear, 0);
  endtask

  task automatic idle_asleep(input int n);
    irq_en = N_IRQ'($urandom);
    irq_flag = ~irq_en;
    for (int i = 0; i < n; i++) begin
      step();
      check("R3", "clk stays off", core_clk_en, 0);
      check("R4", "unenabled flag no wake", wake_pulse, 0);
      check("R3", "no wdt_clear asleep", wdt_clear, 0);
    end
    irq_flag = '0;
  endtask

  // Wait for clocks after the wake edge; returns cycles spent.
  task automatic wait_resume(input bit poke, output int n);
    n = 0;
    while (!core_clk_en && n < OST + 8) begin
      if (poke && n == 3) sleep_req = 1'b1;
      step();
      if (poke && n == 3) begin
        sleep_req = 1'b0;
        check("R10", "sleep_req in hold no wdt_clear", wdt_clear, 0);
        check("R10", "pd kept in hold", status_pd, 0);
      end
      n++;
    end
  endtask

  task automatic wake_irq(input logic [1:0] m, input bit mask, input bit poke);
    int b, n;
    b = $urandom_range(N_IRQ - 1);
    osc_mode = m;
    glb_irq_mask = mask;
    irq_en = N_IRQ'($urandom) | (N_IRQ'(1) << b);
    irq_flag = N_IRQ'(1) << b;
    step();
    irq_flag = '0;
    check("R6", "wdt_clear on irq wake", wdt_clear, 1);
    check("R4", "irq wake is not reset", dev_reset_req, 0);
    if (!exp_hold(m)) begin
      check("R7", "RC/EC clocks resume at once", core_clk_en, 1);
      check("R11", "wake pulse", wake_pulse, 1);
      check("R5", "take_irq", take_irq, exp_take(mask, 0));
    end else begin
      check("R7", "clocks held after wake", core_clk_en, 0);
      wait_resume(poke, n);
      check("R7", "hold length", n, OST);
      check("R11", "wake pulse after hold", wake_pulse, 1);
      check("R5", "take_irq after hold", take_irq, exp_take(mask, 0));
    end
    step();
    check("R11", "wake pulse one cycle", wake_pulse, 0);
    check("R5", "take_irq one cycle", take_irq, 0);
  endtask

  task automatic wake_reset(input logic [1:0] m, input bit use_bor);
    int n;
    osc_mode = m;
    glb_irq_mask = 1'b0;
    if (use_bor) bor_evt = 1'b1; else ext_rst_evt = 1'b1;
    step();
    bor_evt = 1'b0;
    ext_rst_evt = 1'b0;
    check("R9", "reset request", dev_reset_req, 1);
    check("R6", "wdt_clear on reset wake", wdt_clear, 1);
    check("R9", "pd kept", status_pd, 0);
    check("R9", "to kept", status_to, 1);
    if (exp_hold(m)) begin
      wait_resume(1'b0, n);
      check("R7", "hold length reset wake", n, OST);
    end
    check("R11", "wake pulse reset wake", wake_pulse, 1);
    check("R9", "no vector on reset wake", take_irq, exp_take(0, 1));
    step();
    check("R9", "reset request one cycle", dev_reset_req, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    step();
    check("R1", "clk_en in reset", core_clk_en, 1);
    check("R1", "pd in reset", status_pd, 1);
    check("R1", "to in reset", status_to, 1);
    rst_n = 1'b1;
    step();
    check("R1", "clk_en after reset", core_clk_en, 1);
    check("R1", "wake_pulse after reset", wake_pulse, 0);
    check("R1", "reset req after reset", dev_reset_req, 0);
    check("R1", "wdt_clear after reset", wdt_clear, 0);

    // Directed: each oscillator setting, both mask values
    for (int m = 0; m < 4; m++) begin
      enter_sleep();
      idle_asleep(3);
      wake_irq(2'(m), m[0], 1'b0);
    end

    // R10: strobe while asleep, then strobe during the hold
    enter_sleep();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R10", "sleep_req asleep no wdt_clear", wdt_clear, 0);
    check("R10", "still asleep", core_clk_en, 0);
    wake_irq(2'd1, 1'b0, 1'b1);

    // R8: pending interrupt at sleep entry
    osc_mode = 2'd0;
    glb_irq_mask = 1'b1;
    irq_en = 8'h10;
    irq_flag = 8'h10;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R8", "entered sleep", core_clk_en, 0);
    check("R8", "pd cleared", status_pd, 0);
    check("R8", "to set", status_to, 1);
    step();
    irq_flag = '0;
    check("R8", "immediate wake", core_clk_en, 1);
    check("R8", "immediate wake pulse", wake_pulse, 1);
    check("R5", "masked immediate wake no vector", take_irq, 0);
    step();

    // R9: watchdog time-out and power-on while running
    wdt_timeout = 1'b1;
    step();
    wdt_timeout = 1'b0;
    check("R9", "wdt reset request", dev_reset_req, 1);
    check("R9", "wdt clears to", status_to, 0);
    check("R9", "wdt keeps pd", status_pd, 0);
    por_evt = 1'b1;
    wdt_timeout = 1'b1;
    step();
    por_evt = 1'b0;
    wdt_timeout = 1'b0;
    check("R9", "por sets to", status_to, 1);
    check("R9", "por sets pd", status_pd, 1);
    step();

    // Reset-type wakes
    enter_sleep();
    wake_reset(2'd3, 1'b0);
    enter_sleep();
    wake_reset(2'd2, 1'b1);

    // Random mix
    for (int it = 0; it < 14; it++) begin
      enter_sleep();
      idle_asleep(int'($urandom_range(4)) + 1);
      if ($urandom_range(3) == 0) wake_reset(2'($urandom), 1'($urandom));
      else wake_irq(2'($urandom), 1'($urandom), 1'b0);
      n = $urandom_range(3);
      for (int k = 0; k < n; k++) step();
    end

    finish_run();
  end
endmodule